// File: doc/BRIEF.md
# Burst-Tolerant Stream Buffer with Throttle and Packet Shedding

This block sits between a bursty sample producer and a packetizing transport. Words come in on a valid/ready port, each tagged with an end-of-packet flag. They are stored in a first-in first-out buffer and leave on a second valid/ready port in the same order. The buffer compares its own fill level against two configurable levels.

The lower level closes the backpressure loop. Above it, a throttle request goes back to the producer. The request is released only after the fill level has fallen below the lower level by a configurable margin.

The upper level protects the buffer. A packet whose first word arrives while the fill level is at or above the upper level is shed in full: the block accepts all of its words and discards them, and the drop counter records one event.

Telemetry comes out on ports: the peak fill level, the number of shed packets, and the number of cycles in which a word was refused because the buffer was full. A one-cycle session-clear pulse zeroes all three. Every outgoing word also carries the sequence number of its packet, so a receiver can detect gaps.

Top module: `stream_shed_fifo`

## Requirements
- R1: Words of admitted packets leave in arrival order, with their data and end-of-packet flag unchanged. `out_valid` is high exactly when the buffer holds at least one word.
- R2: `throttle` goes high one cycle after the fill level first exceeds the effective high level.
- R3: Once high, `throttle` stays high until the fill level plus `cfg_margin` is strictly below the effective high level. It falls one cycle after that condition holds.
- R4: If the first word of a packet is presented while the fill level is greater than or equal to the effective drop level, the whole packet is shed. `in_ready` stays high for all of its words, and none of them reaches the output.
- R5: `drop_cnt` increases by exactly one for each shed packet, regardless of the packet's length.
- R6: `ovf_cnt` increases by one for every cycle in which `in_valid` is high and `in_ready` is low. This happens only while the buffer is full and inside an admitted packet.
- R7: `peak_occ` equals the maximum fill level seen since reset or the last session clear, and it lags the fill level by one cycle.
- R8: Every output word carries `out_seq`, the index of its packet among emitted packets, modulo 2^16 and starting at 0 after reset. Shed packets do not consume a number.
- R9: The configuration is invalid when `cfg_drop` is less than or equal to `cfg_high`, or when `cfg_drop` exceeds DEPTH. One cycle later, `cfg_error` is high, the effective drop level is DEPTH, and the effective high level is the smaller of `cfg_high` and DEPTH-1. Otherwise both levels are used as given.
- R10: A `sess_clear` pulse sets `peak_occ`, `drop_cnt` and `ovf_cnt` to zero at the next edge. It does not change the buffered data or the sequence number.
- R11: `drop_cnt` and `ovf_cnt` saturate at their all-ones value instead of wrapping.
- R12: After reset, `out_valid`, `throttle`, `cfg_error` and all counters are zero, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer word valid |
| in_ready | output | 1 | Block accepts the presented word |
| in_data | input | DATA_W | Producer word |
| in_last | input | 1 | Word ends its packet |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Transport accepts the output word |
| out_data | output | DATA_W | Output word |
| out_last | output | 1 | Output word ends its packet |
| out_seq | output | 16 | Sequence number of the output word's packet |
| cfg_high | input | OCC_W | Throttle level |
| cfg_drop | input | OCC_W | Shedding level |
| cfg_margin | input | OCC_W | Throttle release margin |
| cfg_error | output | 1 | Configuration was invalid and has been clamped |
| throttle | output | 1 | Request to the producer to slow down |
| sess_clear | input | 1 | Zero the telemetry registers |
| peak_occ | output | OCC_W | Peak fill level |
| drop_cnt | output | CNT_W | Shed packet count |
| ovf_cnt | output | CNT_W | Full-refusal cycle count |

## Verification
The hardest states to reach are a stall inside an admitted packet while the buffer is completely full, and a shed decision at the clamped drop level. The stimulus reaches them by holding the transport off so the buffer fills. It then sends a packet longer than the buffer under a drop level that exceeds DEPTH, so the clamp takes effect. The bench counts the refused cycles before it releases the output. Throttle hysteresis is probed by draining the buffer one word at a time and sampling `throttle` at each fill level around the release point.

// File: rtl/shed_pkg.sv
package shed_pkg;
  typedef enum logic [1:0] {
    GATE_START = 2'd0,
    GATE_KEEP  = 2'd1,
    GATE_SHED  = 2'd2
  } gate_st_t;
endpackage

// File: rtl/shed_cfg.sv
module shed_cfg #(
  parameter int DEPTH = 16,
  parameter int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OCC_W-1:0] cfg_high,
  input  logic [OCC_W-1:0] cfg_drop,
  output logic [OCC_W-1:0] eff_high,
  output logic [OCC_W-1:0] eff_drop,
  output logic             cfg_err
);
  localparam logic [OCC_W-1:0] DEPTH_O = OCC_W'(DEPTH);
  localparam logic [OCC_W-1:0] TOP_HI  = OCC_W'(DEPTH - 1);

  logic bad;
  assign bad = (cfg_drop <= cfg_high) || (cfg_drop > DEPTH_O);

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_high <= TOP_HI;
      eff_drop <= DEPTH_O;
      cfg_err  <= 1'b0;
    end else begin
      cfg_err <= bad;
      if (bad) begin
        eff_drop <= DEPTH_O;
        eff_high <= (cfg_high > TOP_HI) ? TOP_HI : cfg_high;
      end else begin
        eff_drop <= cfg_drop;
        eff_high <= cfg_high;
      end
    end
  end

  AST_CFG_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (eff_drop > eff_high) && (eff_drop <= DEPTH_O)); // R9
endmodule

// File: rtl/shed_fifo_mem.sv
module shed_fifo_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int OCC_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last,
  output logic [OCC_W-1:0]  occ
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam logic [OCC_W-1:0] DEPTH_O = OCC_W'(DEPTH);

  logic [DATA_W:0]     mem [DEPTH];
  logic [ADDR_W-1:0]   wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {wr_last, wr_data};
  end

  assign {rd_last, rd_data} = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (occ < DEPTH_O)); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> (occ != '0)); // R1
endmodule

// File: rtl/shed_gate.sv
module shed_gate
  import shed_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic [OCC_W-1:0] occ,
  input  logic [OCC_W-1:0] eff_drop,
  output logic             in_ready,
  output logic             push,
  output logic             drop_evt,
  output logic             ovf_evt
);
  localparam logic [OCC_W-1:0] DEPTH_O = OCC_W'(DEPTH);

  gate_st_t st;
  logic shed_now, xfer;

  assign shed_now = (st == GATE_START) && (occ >= eff_drop);
  assign in_ready = (st == GATE_SHED) || shed_now || (occ < DEPTH_O);
  assign xfer     = in_valid && in_ready;
  assign push     = xfer && (st != GATE_SHED) && !shed_now;
  assign drop_evt = xfer && shed_now;
  assign ovf_evt  = in_valid && !in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= GATE_START;
    end else if (xfer) begin
      case (st)
        GATE_START: st <= in_last ? GATE_START : (shed_now ? GATE_SHED : GATE_KEEP);
        GATE_KEEP:  st <= in_last ? GATE_START : GATE_KEEP;
        GATE_SHED:  st <= in_last ? GATE_START : GATE_SHED;
        default:    st <= GATE_START;
      endcase
    end
  end

  AST_SHED_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
    (st == GATE_SHED) |-> !push); // R4
  AST_SHED_READY: assert property (@(posedge clk) disable iff (rst)
    (st == GATE_SHED) |-> in_ready); // R4
endmodule

// File: rtl/shed_sat_cnt.sv
module shed_sat_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)         cnt <= '0;
    else if (inc && !(&cnt)) cnt <= cnt + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && !(&cnt)) |=> (cnt == $past(cnt) + 1'b1)); // R5
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    ((&cnt) && !clr) |=> (&cnt)); // R11
endmodule

// File: rtl/shed_stats.sv
module shed_stats #(
  parameter int OCC_W = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [OCC_W-1:0] occ,
  input  logic             drop_evt,
  input  logic             ovf_evt,
  output logic [OCC_W-1:0] peak,
  output logic [CNT_W-1:0] drop_cnt,
  output logic [CNT_W-1:0] ovf_cnt
);
  localparam int NCNT = 2;

  logic [NCNT-1:0]  evt;
  logic [CNT_W-1:0] cnt [NCNT];

  assign evt = {ovf_evt, drop_evt};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    shed_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (clr),
      .inc (evt[g]),
      .cnt (cnt[g])
    );
  end

  assign drop_cnt = cnt[0];
  assign ovf_cnt  = cnt[1];

  always_ff @(posedge clk) begin
    if (rst || clr)     peak <= '0;
    else if (occ > peak) peak <= occ;
  end

  AST_PEAK_COVERS: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (peak >= $past(occ))); // R7
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (peak == '0) && (drop_cnt == '0) && (ovf_cnt == '0)); // R10
endmodule

// File: rtl/stream_shed_fifo.sv
module stream_shed_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 16,
  parameter int OCC_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic [15:0]       out_seq,
  input  logic [OCC_W-1:0]  cfg_high,
  input  logic [OCC_W-1:0]  cfg_drop,
  input  logic [OCC_W-1:0]  cfg_margin,
  output logic              cfg_error,
  output logic              throttle,
  input  logic              sess_clear,
  output logic [OCC_W-1:0]  peak_occ,
  output logic [CNT_W-1:0]  drop_cnt,
  output logic [CNT_W-1:0]  ovf_cnt
);
  localparam logic [OCC_W-1:0] DEPTH_O = OCC_W'(DEPTH);

  logic [OCC_W-1:0] occ, eff_high, eff_drop;
  logic             push, pop, drop_evt, ovf_evt;
  logic [OCC_W:0]   rel_sum;

  shed_cfg #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .cfg_high (cfg_high),
    .cfg_drop (cfg_drop),
    .eff_high (eff_high),
    .eff_drop (eff_drop),
    .cfg_err  (cfg_error)
  );

  shed_gate #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_last  (in_last),
    .occ      (occ),
    .eff_drop (eff_drop),
    .in_ready (in_ready),
    .push     (push),
    .drop_evt (drop_evt),
    .ovf_evt  (ovf_evt)
  );

  shed_fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OCC_W(OCC_W)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .push    (push),
    .wr_data (in_data),
    .wr_last (in_last),
    .pop     (pop),
    .rd_data (out_data),
    .rd_last (out_last),
    .occ     (occ)
  );

  shed_stats #(.OCC_W(OCC_W), .CNT_W(CNT_W)) u_stats (
    .clk      (clk),
    .rst      (rst),
    .clr      (sess_clear),
    .occ      (occ),
    .drop_evt (drop_evt),
    .ovf_evt  (ovf_evt),
    .peak     (peak_occ),
    .drop_cnt (drop_cnt),
    .ovf_cnt  (ovf_cnt)
  );

  assign out_valid = (occ != '0);
  assign pop       = out_valid && out_ready;
  assign rel_sum   = {1'b0, occ} + {1'b0, cfg_margin};

  always_ff @(posedge clk) begin
    if (rst) begin
      throttle <= 1'b0;
    end else if (throttle) begin
      if (rel_sum < {1'b0, eff_high}) throttle <= 1'b0;
    end else if (occ > eff_high) begin
      throttle <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              out_seq <= '0;
    else if (pop && out_last) out_seq <= out_seq + 1'b1;
  end

  AST_THR_RISE: assert property (@(posedge clk) disable iff (rst)
    (occ > eff_high) |=> throttle); // R2
  AST_THR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (throttle && (occ >= eff_high)) |=> throttle); // R3
  AST_REFUSE_FULL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |-> (occ == DEPTH_O)); // R6
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (pop && out_last) |=> (out_seq == $past(out_seq) + 16'd1)); // R8
  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(pop && out_last) |=> $stable(out_seq)); // R8
endmodule

// File: tb/sim_stream_shed_fifo.sv
module sim_stream_shed_fifo;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 16;
  localparam int CNT_W  = 3;
  localparam int OCC_W  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0, sess_clear = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic [OCC_W-1:0] cfg_high = 5'd8, cfg_drop = 5'd12, cfg_margin = 5'd3;
  logic in_ready, out_valid, out_last, cfg_error, throttle;
  logic [DATA_W-1:0] out_data;
  logic [15:0] out_seq;
  logic [OCC_W-1:0] peak_occ;
  logic [CNT_W-1:0] drop_cnt, ovf_cnt;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [32:0] exp_q[$];

  always #5 clk = ~clk;

  stream_shed_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .out_seq(out_seq), .cfg_high(cfg_high), .cfg_drop(cfg_drop),
    .cfg_margin(cfg_margin), .cfg_error(cfg_error), .throttle(throttle),
    .sess_clear(sess_clear), .peak_occ(peak_occ), .drop_cnt(drop_cnt),
    .ovf_cnt(ovf_cnt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Driver: presents one word, records it in the scoreboard if it should emerge.
  task automatic send_word(input logic [15:0] d, input bit last,
                           input bit keep, input logic [15:0] seq);
    bit acc;
    if (keep) exp_q.push_back({seq, last, d});
    in_valid = 1'b1;
    in_data  = d;
    in_last  = last;
    do begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk);
      #1;
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic send_pkt(input int id, input int len, input bit keep,
                          input logic [15:0] seq);
    for (int i = 0; i < len; i++)
      send_word(16'((id << 8) | i), (i == len - 1), keep, seq);
  endtask

  task automatic pop_one();
    out_ready = 1'b1;
    step(1);
    out_ready = 1'b0;
  endtask

  task automatic drain();
    out_ready = 1'b1;
    while (exp_q.size() != 0) @(posedge clk);
    #1;
    out_ready = 1'b0;
    step(1);
  endtask

  // Monitor: compares each transferred word with the scoreboard head (R1, R8).
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1", "unexpected output word", out_data, -1);
      end else begin
        logic [32:0] e;
        e = exp_q.pop_front();
        chk(out_data == e[15:0], "R1", "output data", out_data, e[15:0]);
        chk(out_last == e[16], "R1", "output last flag", out_last, e[16]);
        chk(out_seq == e[32:17], "R8", "sequence number", out_seq, e[32:17]);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(1'b0, "WATCHDOG", "run did not finish", cyc, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R12 reset state
    chk(out_valid == 1'b0, "R12", "out_valid after reset", out_valid, 0);
    chk(throttle == 1'b0, "R12", "throttle after reset", throttle, 0);
    chk(cfg_error == 1'b0, "R12", "cfg_error after reset", cfg_error, 0);
    chk(in_ready == 1'b1, "R12", "in_ready after reset", in_ready, 1);
    chk(peak_occ == 0 && drop_cnt == 0 && ovf_cnt == 0, "R12", "telemetry after reset",
        peak_occ + drop_cnt + ovf_cnt, 0);
    step(1);

    // Fill with the sink stalled: high 8, drop 12, margin 3.
    send_pkt(0, 4, 1'b1, 16'd0);
    send_pkt(1, 4, 1'b1, 16'd1);
    step(1);
    chk(throttle == 1'b0, "R2", "throttle at fill 8", throttle, 0);
    send_pkt(2, 4, 1'b1, 16'd2);
    step(1);
    chk(throttle == 1'b1, "R2", "throttle at fill 12", throttle, 1);
    // R4 packet starting at fill 12 is shed whole
    send_pkt(3, 4, 1'b0, 16'd0);
    step(1);
    chk(drop_cnt == 1, "R5", "drop count after one shed packet", drop_cnt, 1);
    chk(peak_occ == 12, "R7", "peak after fill", peak_occ, 12);
    chk(out_valid == 1'b1, "R1", "out_valid while buffered", out_valid, 1);

    // R10 session clear keeps data
    sess_clear = 1'b1;
    step(1);
    sess_clear = 1'b0;
    chk(peak_occ == 0, "R10", "peak after clear", peak_occ, 0);
    chk(drop_cnt == 0, "R10", "drop count after clear", drop_cnt, 0);
    step(1);
    chk(peak_occ == 12, "R7", "peak regrows after clear", peak_occ, 12);

    // R3 hysteresis: pop down to fill 5, then 4
    for (int i = 0; i < 7; i++) pop_one();
    step(1);
    chk(throttle == 1'b1, "R3", "throttle held at fill 5", throttle, 1);
    pop_one();
    step(1);
    chk(throttle == 1'b0, "R3", "throttle released at fill 4", throttle, 0);
    drain();
    chk(out_valid == 1'b0, "R1", "out_valid when empty", out_valid, 0);

    // R8 shed packet did not take a number
    out_ready = 1'b1;
    send_pkt(4, 2, 1'b1, 16'd3);
    drain();

    // R9 invalid configuration
    cfg_high = 5'd10;
    cfg_drop = 5'd10;
    step(2);
    chk(cfg_error == 1'b1, "R9", "drop equal to high flagged", cfg_error, 1);
    cfg_high = 5'd8;
    cfg_drop = 5'd20;
    step(2);
    chk(cfg_error == 1'b1, "R9", "drop above depth flagged", cfg_error, 1);

    // R6 full stall inside an admitted packet longer than the buffer
    for (int i = 0; i < 16; i++) send_word(16'h0500 | 16'(i), 1'b0, 1'b1, 16'd4);
    fork
      send_word(16'h0510, 1'b0, 1'b1, 16'd4);
    join_none
    step(5);
    chk(ovf_cnt == 5, "R6", "refused cycles while full", ovf_cnt, 5);
    chk(peak_occ == 16, "R7", "peak at full", peak_occ, 16);
    out_ready = 1'b1;
    wait fork;
    for (int i = 17; i < 20; i++) send_word(16'h0500 | 16'(i), (i == 19), 1'b1, 16'd4);
    drain();

    // R9 clamp: shedding at depth even though cfg_drop is 20
    sess_clear = 1'b1;
    step(1);
    sess_clear = 1'b0;
    send_pkt(6, 16, 1'b1, 16'd5);
    send_pkt(7, 2, 1'b0, 16'd0);
    step(1);
    chk(drop_cnt == 1, "R9", "clamped drop level sheds at depth", drop_cnt, 1);
    drain();

    // R11 saturation of the drop counter
    cfg_high = 5'd2;
    cfg_drop = 5'd4;
    cfg_margin = 5'd0;
    step(2);
    chk(cfg_error == 1'b0, "R9", "valid configuration accepted", cfg_error, 0);
    sess_clear = 1'b1;
    step(1);
    sess_clear = 1'b0;
    send_pkt(8, 4, 1'b1, 16'd6);
    for (int i = 0; i < 9; i++) send_pkt(9 + i, 1, 1'b0, 16'd0);
    step(1);
    chk(drop_cnt == 7, "R11", "drop count saturates", drop_cnt, 7);
    drain();
    chk(exp_q.size() == 0, "R1", "scoreboard empty", exp_q.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule